// File: doc/BRIEF.md
# Three-Level Clamped Leg Gate Sequencer

This block drives the four series switches of one three-level, neutral-point-clamped inverter leg. A controller asks for one of three leg states: plus half-bus, clamped to the neutral point, or minus half-bus. It also supplies a dead-time count in clock cycles. The sequencer turns each request into the matching four-switch gate pattern and blanks the switches that change at every commutation. A switch that leaves the on set drops at once. A switch that joins the on set rises only after the programmed dead time.

A jump between the two outer states would commutate all four switches together. The sequencer refuses that jump and routes it through the clamped state, which it holds for at least one dead time before it finishes the move. A state output reports which leg state is actually applied, or a "none" code while the gates are blanking.

The controller is a small machine with four named states. OFF holds all gates low after reset. BLANK is the dead-time interval, where only switches common to the old and new patterns stay on. SETTLED drives the applied pattern and watches the request. DWELL holds the clamped pattern after the first half of an outer-to-outer move. The transitions are: OFF to BLANK on the first clock after reset, with the clamped state as target. SETTLED to BLANK on a valid request that differs from the applied state. BLANK to SETTLED when the count expires on a direct move. BLANK to DWELL when it expires on a detour. DWELL to SETTLED when its count expires.

Top module: `npc_leg_sequencer`

## Requirements
- R1: `gate_o` bit k-1 drives switch k. The applied patterns are plus = 4'b0011 (switches 1, 2), clamped = 4'b0110 (switches 2, 3) and minus = 4'b1100 (switches 3, 4). The request codes on `req_state_i` are 2'b00 clamped, 2'b01 plus and 2'b10 minus.
- R2: `applied_o` equals the code of the state whose full pattern is on `gate_o` (same codes as R1). It reads 2'b11 whenever the gates are blanking or off.
- R3: At a state change, switches in the old pattern but not the new one turn off in the first cycle of blanking. Switches only in the new pattern turn on after max(N,1) blanking cycles, where N is the dead-time count. During blanking only the switches common to both patterns stay on.
- R4: A dead-time count of zero still gives exactly one cycle of blanking.
- R5: The dead-time count is sampled in the cycle a transition starts. Changing `dead_cnt_i` during blanking does not change the blanking length.
- R6: A request from plus to minus, or from minus to plus, first moves to clamped. The clamped pattern is then held for max(N,1)+1 cycles before the second blanking interval. The gates never go directly from one outer pattern to the other.
- R7: While reset is asserted and after it is released, all gates are off and `applied_o` reads 2'b11. The block then blanks for max(N,1) cycles and applies the clamped state.
- R8: Switches 1 and 3 are never on together, and switches 2 and 4 are never on together.
- R9: Request code 2'b11 is ignored: the applied state and gates do not change.
- R10: A request equal to the applied state causes no blanking and no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_state_i | input | 2 | Requested leg state (R1 codes; 2'b11 ignored) |
| dead_cnt_i | input | DT_W | Dead-time length in clock cycles |
| gate_o | output | 4 | Gate commands, bit k-1 for switch k |
| applied_o | output | 2 | Applied leg state, 2'b11 while blanking or off |

## Verification
The assertions check on every cycle that the two complementary switch pairs never conduct together. They also check that the gates never step directly between outer patterns, that a switch rises only after a blanking cycle, that blanking leaves at most one switch on, that the reported state matches the driven pattern, and that the dead-time counter only counts down by one. The exact blanking lengths, including the zero count, the length of the clamped dwell on a detour, the sampling of the count at transition start, and the ignored request code can only be shown by the bench's timed scenarios.

// File: rtl/npc_leg_pkg.sv
package npc_leg_pkg;

    typedef enum logic [1:0] {
        LEG_ZERO  = 2'b00,
        LEG_PLUS  = 2'b01,
        LEG_MINUS = 2'b10,
        LEG_NONE  = 2'b11
    } leg_state_t;

    typedef enum logic [1:0] {
        SQ_OFF     = 2'b00,
        SQ_BLANK   = 2'b01,
        SQ_SETTLED = 2'b10,
        SQ_DWELL   = 2'b11
    } seq_state_t;

    localparam int NUM_SW = 4;

    localparam logic [NUM_SW-1:0] PAT_PLUS  = 4'b0011;
    localparam logic [NUM_SW-1:0] PAT_ZERO  = 4'b0110;
    localparam logic [NUM_SW-1:0] PAT_MINUS = 4'b1100;

    function automatic logic [NUM_SW-1:0] leg_pattern(input leg_state_t s);
        logic [NUM_SW-1:0] p;
        unique case (s)
            LEG_PLUS:  p = PAT_PLUS;
            LEG_ZERO:  p = PAT_ZERO;
            LEG_MINUS: p = PAT_MINUS;
            default:   p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/npc_dead_timer.sv
module npc_dead_timer #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DT_W-1:0] load_val_i,
    output logic            expired_o
);

    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] start_val;

    // a zero count still gives one cycle (R4)
    assign start_val = (load_val_i == '0) ? '0 : load_val_i - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= start_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_hold_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/npc_step_planner.sv
module npc_step_planner
    import npc_leg_pkg::*;
(
    input  leg_state_t cur_i,
    input  logic [1:0] req_i,
    output logic       move_o,
    output leg_state_t step_o,
    output logic       detour_o
);

    leg_state_t req_s;
    logic       req_ok;
    logic       outer_swap;

    always_comb begin
        req_s      = leg_state_t'(req_i);
        req_ok     = (req_s != LEG_NONE);                // R9
        outer_swap = ((cur_i == LEG_PLUS)  && (req_s == LEG_MINUS)) ||
                     ((cur_i == LEG_MINUS) && (req_s == LEG_PLUS));
        move_o     = req_ok && (req_s != cur_i);         // R10
        detour_o   = move_o && outer_swap;               // R6
        step_o     = outer_swap ? LEG_ZERO : req_s;
    end

endmodule

// File: rtl/npc_gate_decoder.sv
module npc_gate_decoder
    import npc_leg_pkg::*;
(
    input  seq_state_t        st_i,
    input  leg_state_t        cur_i,
    input  leg_state_t        nxt_i,
    output logic [NUM_SW-1:0] gate_o,
    output leg_state_t        applied_o
);

    logic [NUM_SW-1:0] cur_pat;
    logic [NUM_SW-1:0] nxt_pat;
    logic              settled;
    logic              blanking;

    always_comb begin
        cur_pat  = leg_pattern(cur_i);
        nxt_pat  = leg_pattern(nxt_i);
        settled  = (st_i == SQ_SETTLED) || (st_i == SQ_DWELL);
        blanking = (st_i == SQ_BLANK);
    end

    for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
        // during blanking only switches shared by both patterns conduct (R3)
        assign gate_o[k] = (settled  && cur_pat[k]) ||
                           (blanking && cur_pat[k] && nxt_pat[k]);
    end

    assign applied_o = settled ? cur_i : LEG_NONE;

endmodule

// File: rtl/npc_leg_sequencer.sv
module npc_leg_sequencer
    import npc_leg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req_state_i,
    input  logic [DT_W-1:0] dead_cnt_i,
    output logic [3:0]      gate_o,
    output logic [1:0]      applied_o
);

    seq_state_t      st_q, st_d;
    leg_state_t      cur_q, cur_d;
    leg_state_t      nxt_q, nxt_d;
    logic            detour_q, detour_d;
    logic [DT_W-1:0] dt_q, dt_d;

    logic            tmr_load;
    logic [DT_W-1:0] tmr_val;
    logic            tmr_expired;

    logic            plan_move;
    leg_state_t      plan_step;
    logic            plan_detour;

    leg_state_t      applied_s;

    npc_dead_timer #(.DT_W(DT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    npc_step_planner u_plan (
        .cur_i    (cur_q),
        .req_i    (req_state_i),
        .move_o   (plan_move),
        .step_o   (plan_step),
        .detour_o (plan_detour)
    );

    // next-state logic
    always_comb begin
        st_d     = st_q;
        cur_d    = cur_q;
        nxt_d    = nxt_q;
        detour_d = detour_q;
        dt_d     = dt_q;
        tmr_load = 1'b0;
        tmr_val  = dead_cnt_i;
        unique case (st_q)
            SQ_OFF: begin
                // first clock after reset: blank towards clamped state (R7)
                st_d     = SQ_BLANK;
                nxt_d    = LEG_ZERO;
                detour_d = 1'b0;
                dt_d     = dead_cnt_i;
                tmr_load = 1'b1;
            end
            SQ_SETTLED: begin
                if (plan_move) begin
                    st_d     = SQ_BLANK;
                    nxt_d    = plan_step;
                    detour_d = plan_detour;
                    dt_d     = dead_cnt_i;   // sampled at start (R5)
                    tmr_load = 1'b1;
                end
            end
            SQ_BLANK: begin
                if (tmr_expired) begin
                    cur_d = nxt_q;
                    if (detour_q) begin
                        st_d     = SQ_DWELL;  // hold clamped state (R6)
                        detour_d = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = dt_q;
                    end else begin
                        st_d = SQ_SETTLED;
                    end
                end
            end
            SQ_DWELL: begin
                if (tmr_expired) begin
                    st_d = SQ_SETTLED;
                end
            end
            default: st_d = SQ_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= SQ_OFF;
            cur_q    <= LEG_NONE;
            nxt_q    <= LEG_ZERO;
            detour_q <= 1'b0;
            dt_q     <= '0;
        end else begin
            st_q     <= st_d;
            cur_q    <= cur_d;
            nxt_q    <= nxt_d;
            detour_q <= detour_d;
            dt_q     <= dt_d;
        end
    end

    // outputs
    npc_gate_decoder u_dec (
        .st_i      (st_q),
        .cur_i     (cur_q),
        .nxt_i     (nxt_q),
        .gate_o    (gate_o),
        .applied_o (applied_s)
    );

    assign applied_o = applied_s;

    p_sw13_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[2]));

    p_sw24_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[1] && gate_o[3]));

    p_no_plus_to_minus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o == PAT_PLUS) |=> (gate_o != PAT_MINUS));

    p_no_minus_to_plus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o == PAT_MINUS) |=> (gate_o != PAT_PLUS));

    p_rise_after_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gate_o & ~$past(gate_o))) |-> ($past(applied_o) == 2'b11));

    p_blank_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_o == 2'b11) |-> ($countones(gate_o) <= 1));

    p_report_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_o != 2'b11) |-> (gate_o == leg_pattern(leg_state_t'(applied_o))));

endmodule

// File: tb/npc_leg_sequencer_test.sv
module npc_leg_sequencer_test;

    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      req = 2'b00;
    logic [DT_W-1:0] dt = 8'd2;
    logic [3:0]      gate;
    logic [1:0]      applied;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    npc_leg_sequencer #(.DT_W(DT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_state_i (req),
        .dead_cnt_i  (dt),
        .gate_o      (gate),
        .applied_o   (applied)
    );

    always #10 clk = ~clk;

    // {request, dead count, expected applied, expected gates}
    localparam logic [15:0] VEC [0:9] = '{
        {2'b01, 8'd2, 2'b01, 4'b0011},
        {2'b00, 8'd0, 2'b00, 4'b0110},
        {2'b10, 8'd3, 2'b10, 4'b1100},
        {2'b10, 8'd1, 2'b10, 4'b1100},
        {2'b01, 8'd2, 2'b01, 4'b0011},
        {2'b10, 8'd4, 2'b10, 4'b1100},
        {2'b00, 8'd1, 2'b00, 4'b0110},
        {2'b11, 8'd1, 2'b00, 4'b0110},
        {2'b10, 8'd0, 2'b10, 4'b1100},
        {2'b01, 8'd0, 2'b01, 4'b0011}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] r, input logic [DT_W-1:0] d);
        @(negedge clk);
        req = r;
        dt  = d;
    endtask

    // count consecutive negedge samples with applied equal to code
    task automatic count_run(input logic [1:0] code, output int n);
        n = 0;
        while (applied == code && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // R8 monitor on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ((gate[0] && gate[2]) || (gate[1] && gate[3])) begin
                errors++;
                $display("FAIL R8 pair overlap: actual=%b expected=no pair", gate);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        // R7 reset state
        repeat (3) @(negedge clk);
        check("R7 gates in reset", gate, 0);
        check("R7 applied in reset", applied, 3);
        dt = 8'd2;
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 gates after release", gate, 0);
        count_run(2'b11, n);
        check("R7 blank before clamp", n, 2);
        check("R7 first applied clamp", applied, 0);
        check("R1 clamp pattern", gate, 4'b0110);

        // table walk: R1 R2 R6 R9 R10
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][15:14], VEC[i][13:6]);
            repeat (30) @(negedge clk);
            check("R1/R2 table applied", applied, VEC[i][5:4]);
            check("R1 table gates", gate, VEC[i][3:0]);
        end
        // now in plus

        // R3 blank length and overlap: plus -> clamp, dt=3
        drive(2'b00, 8'd3);
        @(negedge clk);
        check("R3 leaving switch off at once", gate, 4'b0010);
        count_run(2'b11, n);
        check("R3 blank length", n, 3);
        check("R3 joined after blank", gate, 4'b0110);

        // R4 zero count: clamp -> minus
        drive(2'b10, 8'd0);
        @(negedge clk);
        count_run(2'b11, n);
        check("R4 zero count one cycle", n, 1);
        check("R4 minus applied", applied, 2);

        // R10 same request: no blanking
        drive(2'b10, 8'd5);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (applied != 2'b10 || gate != 4'b1100) n++;
        end
        check("R10 no change on same request", n, 0);

        // R9 ignored code from minus
        drive(2'b11, 8'd1);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (applied != 2'b10 || gate != 4'b1100) n++;
        end
        check("R9 code 3 ignored", n, 0);

        // R6 detour minus -> plus, dt=2
        drive(2'b01, 8'd2);
        @(negedge clk);
        check("R6 first blank keeps S3", gate, 4'b0100);
        count_run(2'b11, n);
        check("R6 first blank length", n, 2);
        check("R6 passes through clamp", applied, 0);
        count_run(2'b00, n);
        check("R6 clamp dwell length", n, 3);
        check("R6 second blank keeps S2", gate, 4'b0010);
        count_run(2'b11, n);
        check("R6 second blank length", n, 2);
        check("R6 reaches plus", applied, 1);

        // R5 count sampled at start: plus -> clamp with 5, changed to 1
        drive(2'b00, 8'd5);
        @(negedge clk);
        dt = 8'd1;
        count_run(2'b11, n);
        check("R5 sampled count holds", n, 5);
        check("R5 clamp applied", applied, 0);

        summary();
        $finish;
    end

endmodule